// File: doc/BRIEF.md
# Paging Batch Stream Generator

This block turns a short queue of pending pages into a one-bit serial paging transmission. A transmission opens with a fixed-length alternating preamble and then carries one or more batches. Each batch starts with a fixed frame-sync word and then carries sixteen 32-bit codeword slots, grouped as eight frames of two slots. Every page holds a 21-bit capcode, a 2-bit function code and up to `MAX_MSG` 20-bit message data words. The low three capcode bits pick the frame in which the address codeword may be sent. Its message codewords follow in the slots directly after it. Any slot with nothing to carry is filled with the idle codeword.

Parity for address and message codewords comes from an internal combinational (31,21) BCH encoder plus an even-parity bit. The bit rate is set outside the block. An external `bit_en` strobe, pulsed once per bit period at 512, 1200 or 2400 bps, moves the stream forward by exactly one bit. Pages are accepted over a valid/ready handshake into a `QDEPTH`-entry queue. A transmission starts when the queue holds a page. It ends after a batch in which no page is left queued and no message word is still pending.

Top module: `pager_batch_gen`

## Requirements
- R1: Every transmission begins with exactly 576 preamble bits that alternate 1,0,1,0 and start with 1. No preamble appears between batches of the same transmission.
- R2: Each batch is the sync word 0x7CD215D8 followed by 16 codeword slots. All words are sent most significant bit first. Consecutive batches follow each other directly.
- R3: Pages are served in arrival order. A page's address codeword goes into the first free slot of frame `capcode[2:0]`, which is slot 2f or 2f+1 of the batch. A page whose frame has already passed in the current batch waits for the same frame in the next batch.
- R4: An address codeword has bit 31 = 0, bits 30:13 = capcode[20:3], bits 12:11 = function code, bits 10:1 = BCH parity over bits 31:11 with generator x^10+x^9+x^8+x^6+x^5+x^3+1, and bit 0 set so that the word has even parity.
- R5: Message word i is taken from `pg_msg[20*i+19:20*i]`, for i below `pg_msg_cnt`. It becomes a codeword with bit 31 = 1, bits 30:11 = the data and the same parity fields as R4. Message codewords fill the slots directly after their address, in index order.
- R6: A message that runs past slot 15 continues in slot 0 of the next batch, right after that batch's sync word.
- R7: Every slot that carries neither an address nor a message holds the idle codeword 0x7A89C197.
- R8: `tx_bit` and `tx_active` change only on clock edges where `bit_en` is high. Each such edge emits exactly one bit. Without strobes, no transmission starts.
- R9: The queue holds `QDEPTH` pages. `pg_ready` is low while it is full. A page offered while `pg_ready` is low is dropped and never transmitted.
- R10: When slot 15 ends with no page queued and no message pending, the next strobe drops `tx_active`. Outside a transmission, `tx_active` and `tx_bit` are both 0.
- R11: Directly after reset, `tx_active` = 0, `tx_bit` = 0 and `pg_ready` = 1.
- R12: Two consecutive pages with the same frame and no messages take both slots of that frame in one batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe per transmitted bit |
| pg_valid | input | 1 | Page offered |
| pg_ready | output | 1 | Queue has room for a page |
| pg_capcode | input | 21 | Page capcode; low three bits give the frame |
| pg_func | input | 2 | Function code carried in the address codeword |
| pg_msg_cnt | input | $clog2(MAX_MSG+1) | Number of message words following the address |
| pg_msg | input | 20*MAX_MSG | Message data words, word i at bits 20i+19:20i |
| tx_bit | output | 1 | Serial output bit |
| tx_active | output | 1 | High while a transmission bit is being sent |

## Verification
The bench targets the placement corners. It sends a page whose frame lies behind an earlier page's frame, which a design that never defers would squeeze into the wrong frame or lose. It sends a message that spills past slot 15, which a wrong design would truncate or restart with a fresh preamble. It sends two pages in one frame, where an off-by-one slot rule would push the second page a whole batch later. It also fills the queue while strobes are held off and then offers one more page, which a wrong design would accept and then send in its frame slot. Every codeword is checked for exact sync and idle values, for its address and data fields, and against an independent BCH syndrome check, so a wrong parity rule or bit order shows up directly.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
    localparam int          CW_BITS   = 32;
    localparam int          PRE_BITS  = 576;
    localparam int          SLOTS     = 16;
    localparam int          SLOT_W    = $clog2(SLOTS);
    localparam int          CAP_W     = 21;
    localparam int          FUNC_W    = 2;
    localparam int          DATA_W    = 20;
    localparam int          INFO_W    = 21;
    localparam logic [31:0] SYNC_CW   = 32'h7CD2_15D8;
    localparam logic [31:0] IDLE_CW   = 32'h7A89_C197;
    localparam logic [10:0] BCH_GEN   = 11'h769;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_SLOT
    } state_e;
endpackage

// File: rtl/pgen_bch.sv
// Combinational (31,21) BCH encoder with appended even-parity bit.
module pgen_bch
    import pgen_pkg::*;
(
    input  logic [INFO_W-1:0] info,
    output logic [CW_BITS-1:0] cw
);
    logic [30:0] rem;

    always_comb begin
        rem = {info, 10'b0};
        for (int i = 30; i >= 10; i--) begin
            if (rem[i]) begin
                rem[i -: 11] = rem[i -: 11] ^ BCH_GEN;
            end
        end
        cw = {info, rem[9:0], ^{info, rem[9:0]}};
    end
endmodule

// File: rtl/pgen_queue.sv
// Small first-in first-out page store, two-process style.
module pgen_queue #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               rd;
        logic [AW-1:0]               wr;
        logic [NW-1:0]               cnt;
    } q_t;

    q_t q_d, q_q;
    logic do_push, do_pop;

    assign push_ready = (q_q.cnt != NW'(DEPTH));
    assign head_valid = (q_q.cnt != '0);
    assign head_data  = q_q.mem[q_q.rd];

    always_comb begin
        q_d     = q_q;
        do_push = push_valid && push_ready;
        do_pop  = pop && head_valid;
        if (do_push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr = (q_q.wr == AW'(DEPTH - 1)) ? '0 : q_q.wr + AW'(1);
        end
        if (do_pop) begin
            q_d.rd = (q_q.rd == AW'(DEPTH - 1)) ? '0 : q_q.rd + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + NW'(1);
            2'b01:   q_d.cnt = q_q.cnt - NW'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/pager_batch_gen.sv
// Paging batch stream generator: preamble, sync, 16 slots per batch.
module pager_batch_gen
    import pgen_pkg::*;
#(
    parameter int QDEPTH  = 4,
    parameter int MAX_MSG = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_en,
    input  logic                              pg_valid,
    output logic                              pg_ready,
    input  logic [CAP_W-1:0]                  pg_capcode,
    input  logic [FUNC_W-1:0]                 pg_func,
    input  logic [$clog2(MAX_MSG+1)-1:0]      pg_msg_cnt,
    input  logic [MAX_MSG*DATA_W-1:0]         pg_msg,
    output logic                              tx_bit,
    output logic                              tx_active
);
    localparam int CNTW = $clog2(MAX_MSG + 1);
    localparam int MSGW = MAX_MSG * DATA_W;
    localparam int ENTW = CAP_W + FUNC_W + CNTW + MSGW;
    localparam int BITW = $clog2(PRE_BITS);

    typedef struct packed {
        state_e            st;
        logic [BITW-1:0]   cnt;
        logic [SLOT_W-1:0] slot;
        logic [CW_BITS-1:0] word;
        logic [CNTW-1:0]   msg_left;
        logic [CNTW-1:0]   msg_idx;
        logic              tx_bit;
        logic              tx_active;
    } regs_t;

    regs_t r_d, r_q;

    // Page queue
    logic [ENTW-1:0] push_data, head_data;
    logic            head_valid, pop;

    assign push_data = {pg_msg, pg_msg_cnt, pg_func, pg_capcode};

    pgen_queue #(.DEPTH(QDEPTH), .WIDTH(ENTW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(pg_valid),
        .push_ready(pg_ready),
        .push_data (push_data),
        .pop       (pop),
        .head_valid(head_valid),
        .head_data (head_data)
    );

    logic [CAP_W-1:0]  head_cap;
    logic [FUNC_W-1:0] head_func;
    logic [CNTW-1:0]   head_cnt;
    logic [MSGW-1:0]   head_msg;
    logic [DATA_W-1:0] msg_word;

    assign head_cap  = head_data[CAP_W-1:0];
    assign head_func = head_data[CAP_W +: FUNC_W];
    assign head_cnt  = head_data[CAP_W + FUNC_W +: CNTW];
    assign head_msg  = head_data[ENTW-1 -: MSGW];

    always_comb begin
        msg_word = head_msg[int'(r_q.msg_idx) * DATA_W +: DATA_W];
    end

    // Codeword encoders: one for the address form, one for the message form
    logic [CW_BITS-1:0] addr_cw, msg_cw;

    pgen_bch u_bch_addr (
        .info({1'b0, head_cap[CAP_W-1:3], head_func}),
        .cw  (addr_cw)
    );

    pgen_bch u_bch_msg (
        .info({1'b1, msg_word}),
        .cw  (msg_cw)
    );

    // Sequencer
    logic              load;
    logic [SLOT_W-1:0] nslot;

    always_comb begin
        r_d   = r_q;
        pop   = 1'b0;
        load  = 1'b0;
        nslot = '0;
        if (bit_en) begin
            case (r_q.st)
                ST_IDLE: begin
                    r_d.tx_active = 1'b0;
                    r_d.tx_bit    = 1'b0;
                    if (head_valid) begin
                        r_d.st  = ST_PRE;
                        r_d.cnt = '0;
                    end
                end
                ST_PRE: begin
                    r_d.tx_active = 1'b1;
                    r_d.tx_bit    = ~r_q.cnt[0];
                    if (r_q.cnt == BITW'(PRE_BITS - 1)) begin
                        r_d.st   = ST_SYNC;
                        r_d.cnt  = '0;
                        r_d.word = SYNC_CW;
                    end else begin
                        r_d.cnt = r_q.cnt + BITW'(1);
                    end
                end
                ST_SYNC, ST_SLOT: begin
                    r_d.tx_active = 1'b1;
                    r_d.tx_bit    = r_q.word[CW_BITS-1];
                    r_d.word      = {r_q.word[CW_BITS-2:0], 1'b0};
                    r_d.cnt       = r_q.cnt + BITW'(1);
                    if (r_q.cnt == BITW'(CW_BITS - 1)) begin
                        r_d.cnt = '0;
                        if (r_q.st == ST_SYNC) begin
                            r_d.st = ST_SLOT;
                            load   = 1'b1;
                            nslot  = '0;
                        end else if (r_q.slot == SLOT_W'(SLOTS - 1)) begin
                            if (r_q.msg_left != '0 || head_valid) begin
                                r_d.st   = ST_SYNC;
                                r_d.word = SYNC_CW;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else begin
                            load  = 1'b1;
                            nslot = r_q.slot + SLOT_W'(1);
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end

        // Pick the content of the slot that starts next
        if (load) begin
            r_d.slot = nslot;
            if (r_q.msg_left != '0) begin
                r_d.word     = msg_cw;
                r_d.msg_idx  = r_q.msg_idx + CNTW'(1);
                r_d.msg_left = r_q.msg_left - CNTW'(1);
                pop          = (r_q.msg_left == CNTW'(1));
            end else if (head_valid && head_cap[2:0] == nslot[SLOT_W-1:1]) begin
                r_d.word = addr_cw;
                if (head_cnt == '0) begin
                    pop = 1'b1;
                end else begin
                    r_d.msg_left = head_cnt;
                    r_d.msg_idx  = '0;
                end
            end else begin
                r_d.word = IDLE_CW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_bit    = r_q.tx_bit;
    assign tx_active = r_q.tx_active;
endmodule

// File: rtl/pgen_chk.sv
// Property checker for pager_batch_gen, attached by bind.
module pgen_chk
    import pgen_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input logic   clk,
    input logic   rst_n,
    input logic   bit_en,
    input logic   pg_valid,
    input logic   pg_ready,
    input logic   pop,
    input logic   tx_bit,
    input logic   tx_active,
    input state_e st,
    input logic   pre_first
);
    localparam int OW = $clog2(QDEPTH + 1);
    logic [OW-1:0] occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + OW'(pg_valid && pg_ready) - OW'(pop);
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(tx_active))); // R8
    AST_PRE_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> tx_bit); // R1
    AST_PRE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st == ST_PRE && !pre_first) |=> (tx_bit != $past(tx_bit))); // R1
    AST_READY_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        pg_ready == (occ < OW'(QDEPTH))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st == ST_IDLE) |=> (!tx_active && !tx_bit)); // R10
endmodule

bind pager_batch_gen pgen_chk #(.QDEPTH(QDEPTH)) u_pgen_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .pg_valid (pg_valid),
    .pg_ready (pg_ready),
    .pop      (pop),
    .tx_bit   (tx_bit),
    .tx_active(tx_active),
    .st       (r_q.st),
    .pre_first(r_q.cnt == '0)
);

// File: tb/pager_batch_gen_bench.sv
module pager_batch_gen_bench;
    localparam logic [31:0] T_SYNC = 32'h7CD215D8;
    localparam logic [31:0] T_IDLE = 32'h7A89C197;
    localparam int          T_PRE  = 576;
    localparam int          T_BATCH = 544;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        strobe_on = 1'b1;
    logic        pg_valid = 1'b0;
    logic        pg_ready;
    logic [20:0] pg_capcode = '0;
    logic [1:0]  pg_func = '0;
    logic [1:0]  pg_msg_cnt = '0;
    logic [59:0] pg_msg = '0;
    logic        tx_bit, tx_active;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pager_batch_gen u_pager_batch_gen (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_capcode(pg_capcode),
        .pg_func(pg_func), .pg_msg_cnt(pg_msg_cnt), .pg_msg(pg_msg),
        .tx_bit(tx_bit), .tx_active(tx_active)
    );

    // Bit strobe: every fourth clock when enabled
    logic [1:0] div = '0;
    logic       en_seen = 1'b0;
    always @(posedge clk) begin
        div     <= div + 2'd1;
        bit_en  <= strobe_on && (div == 2'd3);
        en_seen <= bit_en;
    end

    // Capture of emitted bits, sampled at the falling edge
    bit cap [0:4095];
    int cap_n = 0;
    always @(negedge clk) begin
        if (en_seen && tx_active && cap_n < 4096) begin
            cap[cap_n] = tx_bit;
            cap_n++;
        end
    end

    // Expected slot contents: kind 0 idle, 1 address, 2 message
    int          ek [0:31];
    logic [20:0] ev [0:31];
    string       et [0:31];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input int pos);
        logic [31:0] w;
        for (int k = 0; k < 32; k++) w[31-k] = cap[pos+k];
        return w;
    endfunction

    function automatic bit bch_ok(input logic [31:0] w);
        logic [30:0] r;
        r = w[31:1];
        for (int i = 30; i >= 10; i--) begin
            if (r[i]) r = r ^ (31'(11'h769) << (i - 10));
        end
        return (r[9:0] == 10'd0) && ((^w) == 1'b0);
    endfunction

    task automatic clear_exp();
        for (int i = 0; i < 32; i++) begin
            ek[i] = 0; ev[i] = '0; et[i] = "R7";
        end
        cap_n = 0;
    endtask

    task automatic exp_addr(input int idx, input logic [20:0] cap_code,
                            input logic [1:0] fn, input string tag);
        ek[idx] = 1; ev[idx] = {1'b0, cap_code[20:3], fn}; et[idx] = tag;
    endtask

    task automatic exp_msg(input int idx, input logic [19:0] data, input string tag);
        ek[idx] = 2; ev[idx] = {1'b1, data}; et[idx] = tag;
    endtask

    task automatic push(input logic [20:0] cap_code, input logic [1:0] fn,
                        input logic [1:0] n, input logic [19:0] m0,
                        input logic [19:0] m1, input logic [19:0] m2);
        @(negedge clk);
        pg_capcode = cap_code; pg_func = fn; pg_msg_cnt = n;
        pg_msg = {m2, m1, m0}; pg_valid = 1'b1;
        while (!pg_ready) @(negedge clk);
        @(negedge clk);
        pg_valid = 1'b0;
    endtask

    task automatic run_and_check(input int nb, input string name);
        int bad;
        logic [31:0] w;
        @(negedge clk);
        while (!tx_active) @(negedge clk);
        while (tx_active) @(negedge clk);
        chk(cap_n == T_PRE + nb * T_BATCH, "R8/R2", {name, " stream length"},
            32'(cap_n), 32'(T_PRE + nb * T_BATCH));
        if (cap_n != T_PRE + nb * T_BATCH) return;
        bad = 0;
        for (int i = 0; i < T_PRE; i++) if (cap[i] != ((i % 2) == 0)) bad++;
        chk(bad == 0, "R1", {name, " preamble mismatching bits"}, 32'(bad), 32'd0);
        for (int b = 0; b < nb; b++) begin
            w = word_at(T_PRE + b * T_BATCH);
            chk(w == T_SYNC, "R2", {name, " sync word"}, w, T_SYNC);
            for (int s = 0; s < 16; s++) begin
                int idx = b * 16 + s;
                w = word_at(T_PRE + b * T_BATCH + 32 + s * 32);
                if (ek[idx] == 0) begin
                    chk(w == T_IDLE, "R7", $sformatf("%s idle b%0d s%0d", name, b, s),
                        w, T_IDLE);
                end else begin
                    chk(w[31:11] == ev[idx] && bch_ok(w),
                        {et[idx], (ek[idx] == 1) ? " R4" : " R5"},
                        $sformatf("%s codeword b%0d s%0d", name, b, s),
                        w, {ev[idx], 11'h0});
                end
            end
        end
        repeat (12) @(negedge clk);
        chk(!tx_active && !tx_bit, "R10", {name, " quiet after end"},
            {30'd0, tx_active, tx_bit}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_active && !tx_bit && pg_ready, "R11", "in reset",
            {29'd0, tx_active, tx_bit, pg_ready}, 32'd1);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!tx_active && !tx_bit && pg_ready, "R11", "after reset, empty queue",
            {29'd0, tx_active, tx_bit, pg_ready}, 32'd1);
    endtask

    task automatic t_single();
        clear_exp();
        push(21'h0ABCD3, 2'd2, 2'd0, '0, '0, '0);
        exp_addr(6, 21'h0ABCD3, 2'd2, "R3");
        run_and_check(1, "single");
    endtask

    task automatic t_msg();
        clear_exp();
        push(21'h01F00D, 2'd1, 2'd2, 20'hABCDE, 20'h13579, 20'h0);
        exp_addr(10, 21'h01F00D, 2'd1, "R3");
        exp_msg(11, 20'hABCDE, "R5");
        exp_msg(12, 20'h13579, "R5");
        run_and_check(1, "message");
    endtask

    task automatic t_deferred();
        clear_exp();
        push(21'h154326, 2'd0, 2'd0, '0, '0, '0);
        push(21'h0777A2, 2'd3, 2'd0, '0, '0, '0);
        exp_addr(12, 21'h154326, 2'd0, "R3");
        exp_addr(16 + 4, 21'h0777A2, 2'd3, "R3");
        run_and_check(2, "deferred");
    endtask

    task automatic t_overflow();
        clear_exp();
        push(21'h0FFFFF, 2'd1, 2'd3, 20'h11111, 20'h2468A, 20'hFEDCB);
        exp_addr(14, 21'h0FFFFF, 2'd1, "R3");
        exp_msg(15, 20'h11111, "R5");
        exp_msg(16, 20'h2468A, "R6");
        exp_msg(17, 20'hFEDCB, "R6");
        run_and_check(2, "overflow");
    endtask

    task automatic t_same_frame();
        clear_exp();
        push(21'h000012, 2'd0, 2'd0, '0, '0, '0);
        push(21'h1AAA8A, 2'd2, 2'd0, '0, '0, '0);
        exp_addr(4, 21'h000012, 2'd0, "R12");
        exp_addr(5, 21'h1AAA8A, 2'd2, "R12");
        run_and_check(1, "same frame");
    endtask

    task automatic t_full();
        clear_exp();
        strobe_on = 1'b0;
        repeat (4) @(negedge clk);
        push(21'h100000, 2'd0, 2'd0, '0, '0, '0);
        push(21'h0C0001, 2'd1, 2'd0, '0, '0, '0);
        push(21'h033334, 2'd2, 2'd0, '0, '0, '0);
        push(21'h0ABC07, 2'd3, 2'd0, '0, '0, '0);
        repeat (20) @(negedge clk);
        chk(!pg_ready, "R9", "ready low when full", {31'd0, pg_ready}, 32'd0);
        chk(!tx_active && cap_n == 0, "R8", "no start without strobe",
            {31'd0, tx_active}, 32'd0);
        pg_capcode = 21'h055553; pg_func = 2'd1; pg_msg_cnt = 2'd0; pg_valid = 1'b1;
        repeat (5) @(negedge clk);
        chk(!pg_ready, "R9", "ready stays low while offered", {31'd0, pg_ready}, 32'd0);
        pg_valid = 1'b0;
        strobe_on = 1'b1;
        exp_addr(0, 21'h100000, 2'd0, "R3");
        exp_addr(2, 21'h0C0001, 2'd1, "R3");
        exp_addr(8, 21'h033334, 2'd2, "R3");
        exp_addr(14, 21'h0ABC07, 2'd3, "R3");
        et[6] = "R9";
        run_and_check(1, "full queue");
        chk(pg_ready, "R9", "ready back after drain", {31'd0, pg_ready}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_msg();
        t_deferred();
        t_overflow();
        t_same_frame();
        t_full();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule